// File: doc/BRIEF.md
# Dual-Mode SPI Serial Clock Generator

This block derives the serial clock of an SPI master from a faster module clock. Two division laws are available side by side and one select input picks between them: a linear law that divides by 2*(N+1), with N taken from an 8-bit field, and a power-of-two law that divides by 2^E, with E taken from a 4-bit field. The transfer engine raises an enable for the duration of a transfer. While the enable is low, the counter is held reloaded and the serial clock sits at the idle level that the polarity input selects.

Alongside the serial clock, the block emits one-cycle strobes. One marks the leading edge, the first move away from idle. The other marks the trailing edge, the return to idle. A phase input routes these two strobes onto a sample strobe and a drive strobe for the shift register. Each strobe is high in the same module-clock cycle in which the serial clock shows the matching edge.

All settings, including polarity and phase, are captured only while the enable is low. The transfer engine can therefore rewrite them at any time: a change takes effect at the next transfer start. A power-of-two exponent of zero would ask for an undivided clock, which breaks the rule that the module clock runs at least twice the serial clock rate. That setting is clamped to divide-by-2.

Top module: `spi_sclk_gen`

## Requirements
- R1: With mode_i=1 (linear law), the serial clock period is 2*(N+1) module-clock cycles, where N = lin_i. The first leading edge is seen N+1 cycles after the first rising clock edge at which en_i is high. N=0 gives divide-by-2.
- R2: With mode_i=0 (power-of-two law) and E = exp_i in 1..15, the serial clock period is 2^E module-clock cycles, and each half period lasts 2^(E-1) cycles.
- R3: With mode_i=0 and exp_i=0, the block behaves exactly as divide-by-2: the serial clock toggles on every module clock while enabled.
- R4: In the cycle after any clock edge at which en_i is low, sclk_o equals the polarity captured at that edge, and no strobe is high. The divider restarts from zero, so the next enable begins a fresh half period.
- R5: lead_o is high for exactly the cycle in which sclk_o has just moved from idle to active. trail_o is high for exactly the cycle in which sclk_o has just returned from active to idle. The two are never high together, and sclk_o never changes during a transfer without one of them.
- R6: With phase 0, sample_o follows lead_o and drive_o follows trail_o. With phase 1, sample_o follows trail_o and drive_o follows lead_o. Both are low when neither edge strobe is high.
- R7: mode_i, exp_i, lin_i, cpol_i and cpha_i are captured only at clock edges where en_i is low. Changes made while en_i is high have no effect on any output until en_i has been low for one edge.
- R8: While rst_ni is low, sclk_o, lead_o, trail_o, sample_o and drive_o are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Module clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Transfer active; low holds the divider reloaded and the clock idle |
| mode_i | input | 1 | Division law: 1 = linear 2*(N+1), 0 = power of two 2^E |
| exp_i | input | 4 | Exponent E for the power-of-two law |
| lin_i | input | 8 | Linear divide field N |
| cpol_i | input | 1 | Idle level of the serial clock |
| cpha_i | input | 1 | 0: sample on leading edge, 1: sample on trailing edge |
| sclk_o | output | 1 | Serial clock |
| lead_o | output | 1 | One-cycle strobe marking a leading edge |
| trail_o | output | 1 | One-cycle strobe marking a trailing edge |
| sample_o | output | 1 | Strobe on the edge where data is sampled |
| drive_o | output | 1 | Strobe on the edge where data is driven |

## Verification
The bench builds the block with its default widths: an 8-bit linear field and a 4-bit exponent. These widths put both extremes in reach, the divide-by-2 corners (N=0 and the clamped E=0) as well as the longest settings (N=255 and E=15, which gives a half period of 16384 cycles). The bench runs a full E=15 period, so a counter that is too narrow or a terminal that is off by one shows up as a wrong edge cycle. Short enable pulses that end partway through a half period exercise the reload. Setting changes made in the middle of a transfer exercise the capture-while-idle rule.

// File: rtl/spi_sclk_pkg.sv
package spi_sclk_pkg;
  typedef enum logic {
    DIV_POW2 = 1'b0,
    DIV_LIN  = 1'b1
  } div_mode_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/spi_sclk_cfg.sv
// Captures the divider settings while idle and converts them into a half-period terminal count.
module spi_sclk_cfg
  import spi_sclk_pkg::*;
#(
  parameter int unsigned LIN_W = 8,
  parameter int unsigned EXP_W = 4,
  parameter int unsigned CNT_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             mode_i,
  input  logic [EXP_W-1:0] exp_i,
  input  logic [LIN_W-1:0] lin_i,
  input  logic             cpol_i,
  input  logic             cpha_i,
  output logic [CNT_W-1:0] term_o,
  output logic             cpol_o,
  output logic             cpha_o
);
  localparam int unsigned EXP_N = 1 << EXP_W;

  logic [CNT_W-1:0] pow_tab [EXP_N];
  logic [CNT_W-1:0] term_d;
  div_mode_e        mode_sel;

  // Terminal count for each exponent; E=0 is clamped to divide-by-2.
  for (genvar g = 0; g < EXP_N; g++) begin : g_pow
    if (g == 0) begin : g_clamp
      assign pow_tab[g] = '0;
    end else begin : g_shift
      assign pow_tab[g] = CNT_W'((64'd1 << (g - 1)) - 64'd1);
    end
  end

  assign mode_sel = div_mode_e'(mode_i);

  always_comb begin
    unique case (mode_sel)
      DIV_LIN:  term_d = CNT_W'(lin_i);
      default:  term_d = pow_tab[exp_i];
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      term_o <= '0;
      cpol_o <= 1'b0;
      cpha_o <= 1'b0;
    end else if (!en_i) begin
      term_o <= term_d;
      cpol_o <= cpol_i;
      cpha_o <= cpha_i;
    end
  end
endmodule

// File: rtl/spi_sclk_cnt.sv
// Half-period counter; toggles the phase and registers edge strobes.
module spi_sclk_cnt #(
  parameter int unsigned CNT_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] term_i,
  output logic             phase_o,
  output logic             lead_o,
  output logic             trail_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             hit;

  assign hit = (cnt_q == term_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      phase_o <= 1'b0;
      lead_o  <= 1'b0;
      trail_o <= 1'b0;
    end else if (!en_i) begin
      cnt_q   <= '0;
      phase_o <= 1'b0;
      lead_o  <= 1'b0;
      trail_o <= 1'b0;
    end else begin
      lead_o  <= hit & ~phase_o;
      trail_o <= hit & phase_o;
      if (hit) begin
        cnt_q   <= '0;
        phase_o <= ~phase_o;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/spi_sclk_edge_sel.sv
// Applies polarity and routes edge strobes by phase.
module spi_sclk_edge_sel (
  input  logic phase_i,
  input  logic lead_i,
  input  logic trail_i,
  input  logic cpol_i,
  input  logic cpha_i,
  output logic sclk_o,
  output logic sample_o,
  output logic drive_o
);
  assign sclk_o   = phase_i ^ cpol_i;
  assign sample_o = cpha_i ? trail_i : lead_i;
  assign drive_o  = cpha_i ? lead_i : trail_i;
endmodule

// File: rtl/spi_sclk_gen.sv
module spi_sclk_gen
  import spi_sclk_pkg::*;
#(
  parameter int unsigned LIN_W = 8,
  parameter int unsigned EXP_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             mode_i,
  input  logic [EXP_W-1:0] exp_i,
  input  logic [LIN_W-1:0] lin_i,
  input  logic             cpol_i,
  input  logic             cpha_i,
  output logic             sclk_o,
  output logic             lead_o,
  output logic             trail_o,
  output logic             sample_o,
  output logic             drive_o
);
  // Largest terminal: 2^(2^EXP_W - 2) - 1 for the power law, 2^LIN_W - 1 for the linear law.
  localparam int unsigned CNT_W = max_u(LIN_W, max_u((1 << EXP_W) - 2, 1));

  logic [CNT_W-1:0] term;
  logic             cpol_q;
  logic             cpha_q;
  logic             phase;

  spi_sclk_cfg #(
    .LIN_W (LIN_W),
    .EXP_W (EXP_W),
    .CNT_W (CNT_W)
  ) i_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .mode_i (mode_i),
    .exp_i  (exp_i),
    .lin_i  (lin_i),
    .cpol_i (cpol_i),
    .cpha_i (cpha_i),
    .term_o (term),
    .cpol_o (cpol_q),
    .cpha_o (cpha_q)
  );

  spi_sclk_cnt #(
    .CNT_W (CNT_W)
  ) i_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .term_i  (term),
    .phase_o (phase),
    .lead_o  (lead_o),
    .trail_o (trail_o)
  );

  spi_sclk_edge_sel i_sel (
    .phase_i  (phase),
    .lead_i   (lead_o),
    .trail_i  (trail_o),
    .cpol_i   (cpol_q),
    .cpha_i   (cpha_q),
    .sclk_o   (sclk_o),
    .sample_o (sample_o),
    .drive_o  (drive_o)
  );
endmodule

// File: rtl/spi_sclk_gen_chk.sv
module spi_sclk_gen_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic cpol_i,
  input logic sclk_o,
  input logic lead_o,
  input logic trail_o,
  input logic sample_o,
  input logic drive_o
);
  p_idle_level_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (sclk_o == $past(cpol_i)));

  p_no_strobe_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!lead_o && !trail_o));

  p_edge_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({lead_o, trail_o}));

  p_lead_moves_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lead_o || trail_o) |-> (sclk_o != $past(sclk_o)));

  p_toggle_strobed_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(en_i) && (sclk_o != $past(sclk_o))) |-> (lead_o || trail_o));

  p_min_half_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lead_o |=> !lead_o);

  p_route_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lead_o || trail_o) |-> (sample_o != drive_o));

  p_route_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lead_o || trail_o) |-> (!sample_o && !drive_o));

  always_comb begin
    if (!rst_ni) begin
      a_reset_r8: assert (!sclk_o && !lead_o && !trail_o && !sample_o && !drive_o);
    end
  end
endmodule

bind spi_sclk_gen spi_sclk_gen_chk i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .en_i     (en_i),
  .cpol_i   (cpol_i),
  .sclk_o   (sclk_o),
  .lead_o   (lead_o),
  .trail_o  (trail_o),
  .sample_o (sample_o),
  .drive_o  (drive_o)
);

// File: tb/test_spi_sclk_gen.sv
`timescale 1ns/1ps
module test_spi_sclk_gen;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       mode = 1'b0;
  logic [3:0] e = 4'd0;
  logic [7:0] n = 8'd0;
  logic       cpol = 1'b0;
  logic       cpha = 1'b0;
  logic       sclk, lead, trail, sample, drive;

  int    checks = 0;
  int    failures = 0;
  int    cyc = 0;
  bit    done = 1'b0;
  string cur_req = "R4";

  // reference model state
  int m_t, m_half;
  bit m_lvl, m_cpol, m_cpha, m_lead, m_trail;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_sclk_gen i_spi_sclk_gen (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .en_i     (en),
    .mode_i   (mode),
    .exp_i    (e),
    .lin_i    (n),
    .cpol_i   (cpol),
    .cpha_i   (cpha),
    .sclk_o   (sclk),
    .lead_o   (lead),
    .trail_o  (trail),
    .sample_o (sample),
    .drive_o  (drive)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp_v);
    checks++;
    if (act !== exp_v) begin
      failures++;
      $display("FAIL %s %s at cycle %0d: actual=%0b expected=%0b", req, what, cyc, act, exp_v);
    end
  endtask

  // behavioural reference: settings latched while idle, edge every m_half enabled cycles
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_t = 0; m_lvl = 0; m_cpol = 0; m_cpha = 0; m_half = 1; m_lead = 0; m_trail = 0;
    end else begin
      m_lead = 0;
      m_trail = 0;
      if (!en) begin
        m_t = 0;
        m_lvl = 0;
        m_cpol = cpol;
        m_cpha = cpha;
        if (mode) m_half = int'(n) + 1;
        else if (e == 4'd0) m_half = 1;
        else m_half = 1 << (int'(e) - 1);
      end else begin
        m_t++;
        if (m_t % m_half == 0) begin
          if (!m_lvl) m_lead = 1; else m_trail = 1;
          m_lvl = !m_lvl;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(cur_req, "sclk", sclk, m_lvl ^ m_cpol);
      check("R5", "lead", lead, m_lead);
      check("R5", "trail", trail, m_trail);
      check("R6", "sample", sample, m_cpha ? m_trail : m_lead);
      check("R6", "drive", drive, m_cpha ? m_lead : m_trail);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG && !done) begin
      done = 1'b1;
      failures++;
      checks++;
      $display("FAIL watchdog expired at cycle %0d: actual=running expected=finished", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic idle(input int cycles);
    cur_req = "R4";
    en = 1'b0;
    repeat (cycles) @(negedge clk);
  endtask

  task automatic run(input string req, input bit md, input int ev, input int nv,
                     input bit pol, input bit pha, input int cycles);
    mode = md; e = 4'(ev); n = 8'(nv); cpol = pol; cpha = pha;
    idle(2);
    cur_req = req;
    en = 1'b1;
    repeat (cycles) @(negedge clk);
    idle(3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    check("R8", "sclk", sclk, 1'b0);
    check("R8", "lead", lead, 1'b0);
    check("R8", "trail", trail, 1'b0);
    check("R8", "sample", sample, 1'b0);
    check("R8", "drive", drive, 1'b0);
    rst_n = 1'b1;
    idle(3);

    // R1 linear law
    run("R1", 1'b1, 0, 0,   1'b0, 1'b0, 20);
    run("R1", 1'b1, 0, 3,   1'b1, 1'b1, 40);
    run("R1", 1'b1, 9, 255, 1'b0, 1'b1, 1100);
    // R2 power-of-two law
    run("R2", 1'b0, 1,  0,  1'b0, 1'b0, 20);
    run("R2", 1'b0, 3,  77, 1'b0, 1'b1, 60);
    run("R2", 1'b0, 6,  0,  1'b1, 1'b0, 300);
    run("R2", 1'b0, 15, 0,  1'b1, 1'b1, 33000);
    // R3 exponent zero clamp
    run("R3", 1'b0, 0, 200, 1'b1, 1'b0, 30);
    // R4 enable dropped partway through a half period
    run("R4", 1'b1, 0, 5, 1'b0, 1'b0, 3);
    run("R4", 1'b1, 0, 5, 1'b1, 1'b1, 9);
    run("R4", 1'b1, 0, 5, 1'b0, 1'b0, 30);

    // R7 settings changed mid-transfer are ignored until the next start
    mode = 1'b1; n = 8'd2; cpol = 1'b0; cpha = 1'b0;
    idle(2);
    cur_req = "R7";
    en = 1'b1;
    repeat (5) @(negedge clk);
    n = 8'd7; mode = 1'b0; e = 4'd1; cpol = 1'b1; cpha = 1'b1;
    repeat (25) @(negedge clk);
    idle(1);
    cur_req = "R7";
    en = 1'b1;
    repeat (40) @(negedge clk);
    idle(4);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule